// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block brings a flat panel up and down through a fixed series of timed phases. Software programs four phase delays, a tick prescaler and a power-cycle delay through a small register port. It then sets or clears a power request bit. On a request the sequencer raises the panel supply, then the data-link enable, then the backlight enable. Each step waits a programmed number of base ticks. Power-down runs in the reverse order and ends with a mandatory power-cycle rest period. Two status outputs report "panel fully on" and "power-cycle rest running".

The timing registers are write-protected: a write to them lands only while the key field of the control register holds the unlock pattern. A warm platform reset input can force the panel off at once, but only when software has enabled that option. If all four phase delays are zero, built-in default delays are used instead. The base tick is the reference clock divided by (prescaler + 1). The power-cycle delay counts in coarse units of `CYC_UNIT` base ticks. Software adds one spare unit to the cycle delay to cover the register being written asynchronously to the sequence.

Top module: `panel_pwr_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) all five outputs are 0 and every register reads 0, so the timing registers start locked.
- R2: With prescaler value d, a phase of N base ticks starts at one clock edge and the next phase starts exactly N*(d+1)+1 clock cycles later; a phase with N = 0 lasts one cycle.
- R3: Power-up sequence. When the request bit (control bit 0) reads 1 in the off state, panel_vdd_en rises at the next edge. link_en rises after the power-up phase (ON register bits [12:0]). backlight_en and sts_panel_on rise together after the backlight-on phase (ON register bits [28:16]).
- R4: Power-down sequence. When the request bit reads 0 in the on state, backlight_en and sts_panel_on fall at the next edge. link_en falls after the backlight-off phase (OFF register bits [28:16]). panel_vdd_en falls after the power-down phase (OFF register bits [12:0]).
- R5: sts_cycle_busy rises at the edge where panel_vdd_en falls and stays high for the cycle delay. That delay is the DIV register bits [12:8] times CYC_UNIT base ticks. panel_vdd_en cannot rise while sts_cycle_busy is high, and a pending request starts power-up one cycle after the rest ends.
- R6: A write to address 1, 2 or 3 changes nothing unless the control key field (bits [31:16]) already equals UNLOCK_KEY. A write to the control register (address 0) always takes effect.
- R7: If the four phase fields are all zero when a phase starts, that phase uses the default delays instead: power-up DEF_UP, backlight-on DEF_BLON, power-down DEF_DN, backlight-off DEF_BLOFF base ticks.
- R8: A request change during a running sequence does not interrupt it. The sequence completes to the full-on or full-off state, and the stored request is acted on from there.
- R9: With control bit 1 set, warm_rst high at an edge drops all three enables at that edge, clears the request bit and starts the cycle delay. With control bit 1 clear, warm_rst has no effect.
- R10: Read-back returns each field at its position and all other bits as 0. Address 0: bit 0 is the request, bit 1 is force-off-on-warm-reset, bits [31:16] are the key. Address 1 holds the ON register, address 2 the OFF register. Address 3: bits [7:0] are the prescaler, bits [12:8] are the cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| warm_rst | input | 1 | Platform warm reset event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 on-delays, 2 off-delays, 3 divisor) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| panel_vdd_en | output | 1 | Panel supply enable |
| link_en | output | 1 | Panel data-link enable |
| backlight_en | output | 1 | Backlight enable |
| sts_panel_on | output | 1 | Panel fully powered |
| sts_cycle_busy | output | 1 | Power-cycle rest running |

## Verification
A register write becomes visible on rd_data one edge after the strobe. A change in the request bit reaches the enables one edge later again. Each later enable edge follows the previous one after N*(d+1)+1 cycles of its phase, and a forcing warm reset acts at the very edge that samples it. The bench model steps a cycle counter at every rising edge and compares all outputs and the read port at the falling edge, so each result is checked in the cycle it is due. Separate checks then subtract the recorded edge times and compare them with the programmed delays.

// File: rtl/ppsq_pkg.sv
// Package: shared state encoding, register addresses and field positions
// for the panel power sequencer. Assumes a 32-bit register data path.
package ppsq_pkg;

    localparam int DATA_W = 32;

    // Register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_ON   = 2'd1;
    localparam logic [1:0] ADDR_OFF  = 2'd2;
    localparam logic [1:0] ADDR_DIV  = 2'd3;

    // Field positions
    localparam int CTRL_REQ_BIT = 0;
    localparam int CTRL_PDR_BIT = 1;
    localparam int KEY_LSB      = 16;
    localparam int KEY_W        = 16;
    localparam int HI_FIELD_LSB = 16;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_VDD_WAIT  = 3'd1,
        ST_LINK_WAIT = 3'd2,
        ST_ON        = 3'd3,
        ST_BL_WAIT   = 3'd4,
        ST_LOFF_WAIT = 3'd5,
        ST_CYCLE     = 3'd6
    } seq_state_t;

endpackage

// File: rtl/ppsq_regs.sv
// Register file: control, on-delays, off-delays and divisor registers.
// Timing registers are write-protected by the control key; the control
// register is always writable. Emits the effective delays with the
// all-zero default substitution applied. Assumes DLY_W <= 16.
module ppsq_regs
    import ppsq_pkg::*;
#(
    parameter int DLY_W      = 13,
    parameter int DIV_W      = 8,
    parameter int CYC_W      = 5,
    parameter logic [15:0] UNLOCK_KEY = 16'hA5E1,
    parameter int DEF_UP     = 400,
    parameter int DEF_BLON   = 2000,
    parameter int DEF_DN     = 350,
    parameter int DEF_BLOFF  = 2000,
    localparam int TIM_W     = 4 * DLY_W + DIV_W + CYC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    input  logic              clr_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              power_req,
    output logic              pd_on_warm,
    output logic              unlocked,
    output logic [DLY_W-1:0]  up_dly,
    output logic [DLY_W-1:0]  blon_dly,
    output logic [DLY_W-1:0]  dn_dly,
    output logic [DLY_W-1:0]  bloff_dly,
    output logic [DIV_W-1:0]  div_val,
    output logic [CYC_W-1:0]  cyc_val,
    output logic [TIM_W-1:0]  tim_raw
);

    logic             req_q, pdr_q;
    logic [KEY_W-1:0] key_q;
    logic [DLY_W-1:0] up_q, blon_q, dn_q, bloff_q;
    logic [DIV_W-1:0] div_q;
    logic [CYC_W-1:0] cyc_q;
    logic             all_zero;
    logic             unused_wr;

    assign unused_wr = ^wr_data;
    assign unlocked  = (key_q == UNLOCK_KEY);

    // Control register: always writable, request cleared by forced power-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            pdr_q <= 1'b0;
            key_q <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_CTRL) begin
                req_q <= wr_data[CTRL_REQ_BIT];
                pdr_q <= wr_data[CTRL_PDR_BIT];
                key_q <= wr_data[KEY_LSB +: KEY_W];
            end
            if (clr_req) begin
                req_q <= 1'b0;
            end
        end
    end

    // Timing registers: updated only while the key matches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q    <= '0;
            blon_q  <= '0;
            dn_q    <= '0;
            bloff_q <= '0;
            div_q   <= '0;
            cyc_q   <= '0;
        end else if (wr_en && unlocked) begin
            case (wr_addr)
                ADDR_ON: begin
                    up_q   <= wr_data[DLY_W-1:0];
                    blon_q <= wr_data[HI_FIELD_LSB +: DLY_W];
                end
                ADDR_OFF: begin
                    dn_q    <= wr_data[DLY_W-1:0];
                    bloff_q <= wr_data[HI_FIELD_LSB +: DLY_W];
                end
                ADDR_DIV: begin
                    div_q <= wr_data[DIV_W-1:0];
                    cyc_q <= wr_data[DIV_W +: CYC_W];
                end
                default: ;
            endcase
        end
    end

    // Read multiplexer with unused bits returned as zero
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL: begin
                rd_data[CTRL_REQ_BIT]       = req_q;
                rd_data[CTRL_PDR_BIT]       = pdr_q;
                rd_data[KEY_LSB +: KEY_W]   = key_q;
            end
            ADDR_ON: begin
                rd_data[DLY_W-1:0]               = up_q;
                rd_data[HI_FIELD_LSB +: DLY_W]   = blon_q;
            end
            ADDR_OFF: begin
                rd_data[DLY_W-1:0]               = dn_q;
                rd_data[HI_FIELD_LSB +: DLY_W]   = bloff_q;
            end
            default: begin
                rd_data[DIV_W-1:0]     = div_q;
                rd_data[DIV_W +: CYC_W] = cyc_q;
            end
        endcase
    end

    // Effective delays with default substitution when all four are zero
    always_comb begin
        all_zero  = (up_q == '0) && (blon_q == '0) && (dn_q == '0) && (bloff_q == '0);
        up_dly    = all_zero ? DLY_W'(DEF_UP)    : up_q;
        blon_dly  = all_zero ? DLY_W'(DEF_BLON)  : blon_q;
        dn_dly    = all_zero ? DLY_W'(DEF_DN)    : dn_q;
        bloff_dly = all_zero ? DLY_W'(DEF_BLOFF) : bloff_q;
    end

    assign power_req  = req_q;
    assign pd_on_warm = pdr_q;
    assign div_val    = div_q;
    assign cyc_val    = cyc_q;
    assign tim_raw    = {up_q, blon_q, dn_q, bloff_q, div_q, cyc_q};

endmodule

// File: rtl/ppsq_timer.sv
// Phase timer: a prescaler that divides the clock by (div+1) into base
// ticks, and a countdown of base ticks. A load restarts both and captures
// the divider, so a phase of N ticks expires exactly N*(div+1) cycles
// after the load edge.
module ppsq_timer #(
    parameter int TMR_W = 15,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic [DIV_W-1:0] div,
    output logic             expired
);

    logic [TMR_W-1:0] rem_q;
    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;

    // Prescale the clock and count remaining base ticks down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            pre_q <= '0;
            div_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
            pre_q <= '0;
            div_q <= div;
        end else if (rem_q != '0) begin
            if (pre_q == div_q) begin
                pre_q <= '0;
                rem_q <= rem_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired = (rem_q == '0);

endmodule

// File: rtl/ppsq_fsm.sv
// Sequencing state machine. Reads the request only in the stable off and
// on states, loads the phase timer on each phase entry, and decodes the
// panel enables and status from its state. A forced power-off jumps from
// any powered state straight into the cycle rest.
module ppsq_fsm
    import ppsq_pkg::*;
#(
    parameter int DLY_W    = 13,
    parameter int CYC_W    = 5,
    parameter int TMR_W    = 15,
    parameter int CYC_UNIT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             force_off,
    input  logic             expired,
    input  logic [DLY_W-1:0] up_dly,
    input  logic [DLY_W-1:0] blon_dly,
    input  logic [DLY_W-1:0] dn_dly,
    input  logic [DLY_W-1:0] bloff_dly,
    input  logic [CYC_W-1:0] cyc_val,
    output logic             load,
    output logic [TMR_W-1:0] load_val,
    output logic             vdd_en,
    output logic             link_en,
    output logic             bl_en,
    output logic             panel_on,
    output logic             cycle_busy
);

    seq_state_t       st_q, st_nxt;
    logic [TMR_W-1:0] cyc_ticks;

    assign cyc_ticks = TMR_W'(cyc_val) * TMR_W'(CYC_UNIT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_nxt;
    end

    // Next state and timer load selection
    always_comb begin
        st_nxt   = st_q;
        load     = 1'b0;
        load_val = '0;
        if (force_off && st_q != ST_OFF && st_q != ST_CYCLE) begin
            st_nxt   = ST_CYCLE;
            load     = 1'b1;
            load_val = cyc_ticks;
        end else begin
            case (st_q)
                ST_OFF: if (req && !force_off) begin
                    st_nxt   = ST_VDD_WAIT;
                    load     = 1'b1;
                    load_val = TMR_W'(up_dly);
                end
                ST_VDD_WAIT: if (expired) begin
                    st_nxt   = ST_LINK_WAIT;
                    load     = 1'b1;
                    load_val = TMR_W'(blon_dly);
                end
                ST_LINK_WAIT: if (expired) st_nxt = ST_ON;
                ST_ON: if (!req) begin
                    st_nxt   = ST_BL_WAIT;
                    load     = 1'b1;
                    load_val = TMR_W'(bloff_dly);
                end
                ST_BL_WAIT: if (expired) begin
                    st_nxt   = ST_LOFF_WAIT;
                    load     = 1'b1;
                    load_val = TMR_W'(dn_dly);
                end
                ST_LOFF_WAIT: if (expired) begin
                    st_nxt   = ST_CYCLE;
                    load     = 1'b1;
                    load_val = cyc_ticks;
                end
                ST_CYCLE: if (expired) st_nxt = ST_OFF;
                default: st_nxt = ST_OFF;
            endcase
        end
    end

    // Output decode from the current state
    always_comb begin
        vdd_en     = (st_q == ST_VDD_WAIT) || (st_q == ST_LINK_WAIT) || (st_q == ST_ON) ||
                     (st_q == ST_BL_WAIT)  || (st_q == ST_LOFF_WAIT);
        link_en    = (st_q == ST_LINK_WAIT) || (st_q == ST_ON) || (st_q == ST_BL_WAIT);
        bl_en      = (st_q == ST_ON);
        panel_on   = (st_q == ST_ON);
        cycle_busy = (st_q == ST_CYCLE);
    end

endmodule

// File: rtl/panel_pwr_seq.sv
// Top of the flat panel power sequencer: register file, phase timer and
// sequencing state machine. Assumes a single reference clock and a
// synchronous active-low reset; warm_rst is synchronous to clk.
module panel_pwr_seq
    import ppsq_pkg::*;
#(
    parameter int DLY_W      = 13,
    parameter int DIV_W      = 8,
    parameter int CYC_W      = 5,
    parameter int CYC_UNIT   = 1000,
    parameter logic [15:0] UNLOCK_KEY = 16'hA5E1,
    parameter int DEF_UP     = 400,
    parameter int DEF_BLON   = 2000,
    parameter int DEF_DN     = 350,
    parameter int DEF_BLOFF  = 2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        warm_rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        panel_vdd_en,
    output logic        link_en,
    output logic        backlight_en,
    output logic        sts_panel_on,
    output logic        sts_cycle_busy
);

    localparam int UNIT_W = $clog2(CYC_UNIT + 1);
    localparam int TMR_W  = (DLY_W > CYC_W + UNIT_W) ? DLY_W : CYC_W + UNIT_W;
    localparam int TIM_W  = 4 * DLY_W + DIV_W + CYC_W;

    logic             power_req, pd_on_warm, unlocked, force_off;
    logic [DLY_W-1:0] up_dly, blon_dly, dn_dly, bloff_dly;
    logic [DIV_W-1:0] div_val;
    logic [CYC_W-1:0] cyc_val;
    logic [TIM_W-1:0] tim_raw;
    logic             tmr_load, tmr_expired;
    logic [TMR_W-1:0] tmr_load_val;

    // Warm reset forces power-off only when software enabled it
    assign force_off = pd_on_warm && warm_rst;

    ppsq_regs #(
        .DLY_W(DLY_W), .DIV_W(DIV_W), .CYC_W(CYC_W), .UNLOCK_KEY(UNLOCK_KEY),
        .DEF_UP(DEF_UP), .DEF_BLON(DEF_BLON), .DEF_DN(DEF_DN), .DEF_BLOFF(DEF_BLOFF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .clr_req(force_off), .rd_data(rd_data),
        .power_req(power_req), .pd_on_warm(pd_on_warm), .unlocked(unlocked),
        .up_dly(up_dly), .blon_dly(blon_dly), .dn_dly(dn_dly), .bloff_dly(bloff_dly),
        .div_val(div_val), .cyc_val(cyc_val), .tim_raw(tim_raw)
    );

    ppsq_timer #(.TMR_W(TMR_W), .DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_load_val),
        .div(div_val), .expired(tmr_expired)
    );

    ppsq_fsm #(.DLY_W(DLY_W), .CYC_W(CYC_W), .TMR_W(TMR_W), .CYC_UNIT(CYC_UNIT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(power_req), .force_off(force_off),
        .expired(tmr_expired), .up_dly(up_dly), .blon_dly(blon_dly), .dn_dly(dn_dly),
        .bloff_dly(bloff_dly), .cyc_val(cyc_val), .load(tmr_load), .load_val(tmr_load_val),
        .vdd_en(panel_vdd_en), .link_en(link_en), .bl_en(backlight_en),
        .panel_on(sts_panel_on), .cycle_busy(sts_cycle_busy)
    );

endmodule

// File: rtl/panel_pwr_seq_chk.sv
// Checker for the panel power sequencer: ordering of the enables, the
// cycle rest gate, register lock and forced power-off. Bound to the top.
module panel_pwr_seq_chk #(
    parameter int TW = 65
) (
    input logic          clk,
    input logic          rst_n,
    input logic          force_off,
    input logic          vdd_en,
    input logic          link_en,
    input logic          bl_en,
    input logic          panel_on,
    input logic          cycle_busy,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic          unlocked,
    input logic [TW-1:0] tim_raw
);

    p_bl_needs_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bl_en |-> (link_en && vdd_en));

    p_bl_after_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bl_en) |-> $past(link_en));

    p_link_after_vdd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_en) |-> $past(vdd_en));

    p_on_with_bl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_on) |-> $rose(bl_en));

    p_vdd_last_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vdd_en) |-> (!link_en && !bl_en));

    p_link_off_before_vdd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(link_en) && !$past(force_off)) |-> vdd_en);

    p_rest_follows_vdd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vdd_en) |-> cycle_busy);

    p_no_vdd_in_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_busy |-> !vdd_en);

    p_locked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 2'd0 && !unlocked) |=> $stable(tim_raw));

    p_force_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (!vdd_en && !link_en && !bl_en));

endmodule

bind panel_pwr_seq panel_pwr_seq_chk #(.TW(TIM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .force_off(force_off), .vdd_en(panel_vdd_en),
    .link_en(link_en), .bl_en(backlight_en), .panel_on(sts_panel_on),
    .cycle_busy(sts_cycle_busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .unlocked(unlocked), .tim_raw(tim_raw)
);

// File: tb/panel_pwr_seq_tb.sv
// Bench: behavioural cycle-count model compared on every clock, plus
// edge-spacing checks against the programmed delays.
module panel_pwr_seq_tb;

    localparam int UNIT = 20;
    localparam logic [15:0] KEY = 16'hA5E1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        vdd, link, bl, on_sts, cyc_sts;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    panel_pwr_seq #(.CYC_UNIT(UNIT), .UNLOCK_KEY(KEY)) u_dut (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .panel_vdd_en(vdd),
        .link_en(link), .backlight_en(bl), .sts_panel_on(on_sts), .sts_cycle_busy(cyc_sts)
    );

    // ---------------- reference model (cycle counts) ----------------
    int m_ph, m_rem;
    logic m_req, m_pdr;
    logic [15:0] m_key;
    int m_up, m_blon, m_dn, m_bloff, m_div, m_cyc;

    function automatic int eff(int sel);
        bit z = (m_up == 0 && m_blon == 0 && m_dn == 0 && m_bloff == 0);
        case (sel)
            0: return z ? 400  : m_up;
            1: return z ? 2000 : m_blon;
            2: return z ? 350  : m_dn;
            default: return z ? 2000 : m_bloff;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ph = 0; m_rem = 0; m_req = 0; m_pdr = 0; m_key = 0;
            m_up = 0; m_blon = 0; m_dn = 0; m_bloff = 0; m_div = 0; m_cyc = 0;
        end else begin
            bit frc;
            frc = m_pdr && warm_rst;
            if (frc && m_ph >= 1 && m_ph <= 5) begin
                m_ph = 6; m_rem = m_cyc * UNIT * (m_div + 1);
            end else begin
                case (m_ph)
                    0: if (m_req && !frc) begin m_ph = 1; m_rem = eff(0) * (m_div + 1); end
                    1: if (m_rem == 0) begin m_ph = 2; m_rem = eff(1) * (m_div + 1); end else m_rem--;
                    2: if (m_rem == 0) m_ph = 3; else m_rem--;
                    3: if (!m_req) begin m_ph = 4; m_rem = eff(3) * (m_div + 1); end
                    4: if (m_rem == 0) begin m_ph = 5; m_rem = eff(2) * (m_div + 1); end else m_rem--;
                    5: if (m_rem == 0) begin m_ph = 6; m_rem = m_cyc * UNIT * (m_div + 1); end else m_rem--;
                    default: if (m_rem == 0) m_ph = 0; else m_rem--;
                endcase
            end
            if (wr_en) begin
                if (wr_addr == 2'd0) begin
                    m_req = wr_data[0]; m_pdr = wr_data[1]; m_key = wr_data[31:16];
                end else if (m_key == KEY) begin
                    case (wr_addr)
                        2'd1: begin m_up = int'(wr_data[12:0]); m_blon = int'(wr_data[28:16]); end
                        2'd2: begin m_dn = int'(wr_data[12:0]); m_bloff = int'(wr_data[28:16]); end
                        default: begin m_div = int'(wr_data[7:0]); m_cyc = int'(wr_data[12:8]); end
                    endcase
                end
            end
            if (frc) m_req = 0;
        end
    end

    function automatic logic [31:0] exp_rd(logic [1:0] a);
        case (a)
            2'd0: return {m_key, 14'b0, m_pdr, m_req};
            2'd1: return {3'b0, 13'(m_blon), 3'b0, 13'(m_up)};
            2'd2: return {3'b0, 13'(m_bloff), 3'b0, 13'(m_dn)};
            default: return {19'b0, 5'(m_cyc), 8'(m_div)};
        endcase
    endfunction

    // ---------------- per-cycle compare and edge monitor ----------------
    int t_vdd_up, t_vdd_dn, t_link_up, t_link_dn, t_bl_up, t_bl_dn, t_cyc_dn;
    logic p_vdd = 0, p_link = 0, p_bl = 0, p_cyc = 0;

    always @(negedge clk) begin
        if (cycles > 0) begin
            logic [36:0] act, expv;
            act  = {vdd, link, bl, on_sts, cyc_sts, rd_data};
            expv = {(m_ph >= 1 && m_ph <= 5), (m_ph >= 2 && m_ph <= 4), (m_ph == 3),
                    (m_ph == 3), (m_ph == 6), exp_rd(rd_addr)};
            vectors++;
            if (act !== expv) begin
                fails++;
                $display("FAIL %s: outputs {vdd,link,bl,on,cyc,rd} act %h exp %h at cycle %0d",
                         cur_req, act, expv, cycles);
            end
        end
        if (vdd && !p_vdd) t_vdd_up = cycles;
        if (!vdd && p_vdd) t_vdd_dn = cycles;
        if (link && !p_link) t_link_up = cycles;
        if (!link && p_link) t_link_dn = cycles;
        if (bl && !p_bl) t_bl_up = cycles;
        if (!bl && p_bl) t_bl_dn = cycles;
        if (!cyc_sts && p_cyc) t_cyc_dn = cycles;
        p_vdd = vdd; p_link = link; p_bl = bl; p_cyc = cyc_sts;
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, longint act, longint expv);
        vectors++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: act %0h exp %0h", tag, act, expv);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    // sel 0: panel on; 1: idle (all off, rest over); 2: rest running
    task automatic wait_for(int sel);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk); #1;
            if (sel == 0 && on_sts) return;
            if (sel == 1 && !vdd && !cyc_sts && !on_sts) return;
            if (sel == 2 && cyc_sts) return;
        end
        fails++;
        $display("FAIL %s: wait condition %0d never reached", cur_req, sel);
    endtask

    task automatic pulse_warm();
        @(negedge clk); #1; warm_rst = 1'b1;
        @(negedge clk); #1; warm_rst = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: act timeout exp completion");
        summary();
    end

    // ---------------- stimulus ----------------
    initial begin
        int dn_before;
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 vdd", vdd, 0);
        chk("R1 cycle busy", cyc_sts, 0);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #1;
            chk("R1 register read", rd_data, 0);
        end

        // R6 locked write ignored
        cur_req = "R6";
        wr(2'd1, 32'h0005_0003);
        rd_addr = 2'd1; #1;
        chk("R6 locked ON write", rd_data, 0);

        // R10 unlock and field read-back
        cur_req = "R10";
        wr(2'd0, {KEY, 16'h0});
        rd_addr = 2'd0; #1;
        chk("R10 ctrl read", rd_data, {KEY, 16'h0});
        wr(2'd1, 32'hFFE5_E003);
        rd_addr = 2'd1; #1;
        chk("R10 ON read masks", rd_data, 32'h1FE5_0003);
        wr(2'd1, (32'd5 << 16) | 32'd3);
        wr(2'd2, (32'd2 << 16) | 32'd4);
        wr(2'd3, (32'd2 << 8) | 32'd1);
        rd_addr = 2'd3; #1;
        chk("R10 DIV read", rd_data, 32'h0000_0201);

        // R2/R3 power-up spacing, d=1
        cur_req = "R3";
        wr(2'd0, {KEY, 16'h1});
        wait_for(0);
        chk("R2 vdd->link cycles", t_link_up - t_vdd_up, 3 * 2 + 1);
        chk("R3 link->backlight cycles", t_bl_up - t_link_up, 5 * 2 + 1);

        // R4 power-down, R5 request during rest
        cur_req = "R4";
        wr(2'd0, {KEY, 16'h0});
        wait_for(2);
        cur_req = "R5";
        wr(2'd0, {KEY, 16'h1});
        wait_for(0);
        chk("R4 backlight->link off", t_link_dn - t_bl_dn, 2 * 2 + 1);
        chk("R4 link->vdd off", t_vdd_dn - t_link_dn, 4 * 2 + 1);
        chk("R5 rest then power-up", t_vdd_up - t_vdd_dn, 2 * UNIT * 2 + 1 + 1);

        // R8 request reversal during power-down
        cur_req = "R8";
        dn_before = t_vdd_dn;
        wr(2'd0, {KEY, 16'h0});
        wr(2'd0, {KEY, 16'h1});
        wait_for(0);
        chk("R8 down completed before up", (t_vdd_dn != dn_before) && (t_vdd_up > t_vdd_dn), 1);
        // R8 request reversal during power-up
        wr(2'd0, {KEY, 16'h0});
        wait_for(1);
        wr(2'd0, {KEY, 16'h1});
        wr(2'd0, {KEY, 16'h0});
        wait_for(0);
        chk("R8 up completed to full on", on_sts, 1);
        wait_for(1);

        // R7 defaults with all-zero delays, d=0, cycle 1 unit
        cur_req = "R7";
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);
        wr(2'd3, (32'd1 << 8));
        wr(2'd0, {KEY, 16'h1});
        wait_for(0);
        chk("R7 default power-up", t_link_up - t_vdd_up, 401);
        chk("R7 default backlight-on", t_bl_up - t_link_up, 2001);
        wr(2'd0, {KEY, 16'h0});
        wait_for(1);
        chk("R7 default backlight-off", t_link_dn - t_bl_dn, 2001);
        chk("R7 default power-down", t_vdd_dn - t_link_dn, 351);
        chk("R5 rest length", t_cyc_dn - t_vdd_dn, UNIT + 1);

        // R9 warm reset ignored, then forced off
        cur_req = "R9";
        wr(2'd1, (32'd5 << 16) | 32'd3);
        wr(2'd2, (32'd2 << 16) | 32'd4);
        wr(2'd3, (32'd2 << 8) | 32'd1);
        wr(2'd0, {KEY, 16'h1});
        wait_for(0);
        pulse_warm();
        chk("R9 ignored without enable", on_sts, 1);
        rd_addr = 2'd0; #1;
        chk("R9 request kept", rd_data[0], 1);
        wr(2'd0, {KEY, 16'h3});
        pulse_warm();
        chk("R9 forced enables off", {vdd, link, bl}, 0);
        chk("R9 forced rest", cyc_sts, 1);
        chk("R9 request cleared", rd_data[0], 0);
        wait_for(1);

        // R5 zero cycle delay lasts one cycle
        cur_req = "R5";
        wr(2'd0, {KEY, 16'h0});
        wr(2'd3, 32'd1);
        wr(2'd0, {KEY, 16'h1});
        wait_for(0);
        wr(2'd0, {KEY, 16'h0});
        wait_for(1);
        chk("R5 zero rest", t_cyc_dn - t_vdd_dn, 1);

        // R6 relock and ignored write
        cur_req = "R6";
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0011_0022);
        rd_addr = 2'd1; #1;
        chk("R6 relocked ON write", rd_data, 32'h0005_0003);
        repeat (4) @(negedge clk);
        summary();
    end

endmodule